// File: doc/BRIEF.md
# PCI Configuration-Space Target with Base-Address Sizing

This block answers configuration reads and writes for a single PCI function. A request names a register by its byte offset, carries four byte enables and, for a write, a data word. A read returns its data one cycle later with a valid strobe. The block reports a fixed identity word and a fixed class/revision word. It holds a command register, of which only the bits in a parameter mask are kept, and one memory base-address register whose window size is a parameter.

Host software finds the window size by writing all ones to the base-address register and reading it back. The block answers that probe with the window's address mask. Any other write is stored as written, or masked to the window when the masking variant is selected. A vendor-specific init-enable word can be read back and is also driven out to the attached device. A decode output tells the attached device when an incoming memory address falls inside the programmed window while memory decoding is enabled.

Top module: `pcicfg_target`

## Requirements
- R1: After reset the command, base-address and init-enable registers read 0, `init_en_o` is 0, `mem_hit_o` is 0 and `rd_valid_o` is low.
- R2: A read of offset 0x00 returns the constant `ID_WORD` (default 0x0001121A), and writes to offset 0x00 leave it unchanged.
- R3: A read of offset 0x08 returns the constant `CLASS_WORD` (default 0x04000002), and writes to it have no effect.
- R4: A write to offset 0x04 stores only the bits set in `CMD_MASK` (default 0x3), and every other command bit reads 0.
- R5: A write to offset 0x10 with all four byte enables set and data 0xFFFFFFFF makes the register read back the window mask, all ones above bit `WIN_BITS` and zeros below it (0xFF000000 for the default 16 MB window).
- R6: Any other write to offset 0x10 is stored as given when `BAR_MASK_WR` is 0 (the default). When it is 1, the stored value is ANDed with the window mask.
- R7: A write to offset 0x40 stores an init-enable word that reads back, and `init_en_o` shows the new value from the cycle after the write.
- R8: Byte enable bit n (n = 0..3) selects data bits 8n+7..8n. Only the enabled bytes of a writable register change, and a probe with any byte enable clear is an ordinary write.
- R9: A read of any offset other than 0x00, 0x04, 0x08, 0x10 and 0x40 returns 0, and a write to such an offset changes no register. The two low offset bits are ignored.
- R10: `rd_valid_o` is high for exactly one cycle, in the cycle after each accepted read request, with `rd_data_o` valid in that cycle. A write request never raises `rd_valid_o`.
- R11: `mem_hit_o` is high exactly when command bit 1 is set and `mem_addr_i` bits 31 down to `WIN_BITS` equal the same bits of the base-address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_off_i | input | 8 | Register byte offset |
| req_be_i | input | 4 | Byte enables for a write |
| req_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| init_en_o | output | 32 | Init-enable word for the attached device |
| mem_addr_i | input | 32 | Memory address to decode |
| mem_hit_o | output | 1 | Address falls in the enabled window |

## Verification
The base-address register is probed with full all-ones writes, with all-ones data under partial byte enables, and with ordinary addresses. This separates the sizing path from plain storage and from byte merging. Command writes with every bit set and with alternating bits show whether the mask is applied after the merge. Address sweeps at the window edges, just outside them, and with memory decode switched off separate the comparison width from the enable. Reads of reserved offsets made after writes to them show whether a write reached any register.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;
  // word indices (byte offset / 4) of implemented registers
  localparam logic [5:0] IDX_IDENT = 6'h00;
  localparam logic [5:0] IDX_CMD   = 6'h01;
  localparam logic [5:0] IDX_CLASS = 6'h02;
  localparam logic [5:0] IDX_BASE  = 6'h04;
  localparam logic [5:0] IDX_INIT  = 6'h10;

  // merge enabled bytes of new data over old data
  function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                           input logic [31:0] new_v,
                                           input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) begin
      r[b*8 +: 8] = be[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/pcicfg_rstsync.sv
module pcicfg_rstsync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/pcicfg_regs.sv
module pcicfg_regs
  import pcicfg_pkg::*;
#(
  parameter logic [31:0] CMD_MASK    = 32'h0000_0003,
  parameter int          WIN_BITS    = 24,
  parameter bit          BAR_MASK_WR = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [5:0]  wr_idx_i,
  input  logic [3:0]  wr_be_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] cmd_o,
  output logic [31:0] base_o,
  output logic [31:0] init_o
);
  localparam logic [31:0] WIN_MASK = ~((32'h1 << WIN_BITS) - 32'h1);

  logic [31:0] cmd_q, base_q, init_q;
  logic [31:0] cmd_d, base_d, init_d;
  logic        cmd_ce, base_ce, init_ce;
  logic [31:0] base_merged, base_stored;
  logic        size_probe;

  assign cmd_ce  = wr_en_i && (wr_idx_i == IDX_CMD);
  assign base_ce = wr_en_i && (wr_idx_i == IDX_BASE);
  assign init_ce = wr_en_i && (wr_idx_i == IDX_INIT);

  assign base_merged = be_merge(base_q, wr_data_i, wr_be_i);
  assign size_probe  = (wr_be_i == 4'hF) && (wr_data_i == 32'hFFFF_FFFF);

  generate
    if (BAR_MASK_WR) begin : g_mask_store
      assign base_stored = base_merged & WIN_MASK;
    end else begin : g_raw_store
      assign base_stored = base_merged;
    end
  endgenerate

  always_comb begin
    cmd_d  = be_merge(cmd_q, wr_data_i, wr_be_i) & CMD_MASK;
    base_d = size_probe ? WIN_MASK : base_stored;
    init_d = be_merge(init_q, wr_data_i, wr_be_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      base_q <= '0;
      init_q <= '0;
    end else begin
      if (cmd_ce)  cmd_q  <= cmd_d;
      if (base_ce) base_q <= base_d;
      if (init_ce) init_q <= init_d;
    end
  end

  assign cmd_o  = cmd_q;
  assign base_o = base_q;
  assign init_o = init_q;

  a_r4_cmd_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ce |=> ((cmd_q & ~CMD_MASK) == 32'h0));

  a_r5_size_answer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_ce && wr_be_i == 4'hF && wr_data_i == 32'hFFFF_FFFF) |=> (base_q == WIN_MASK));

  a_r9_base_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !base_ce |=> $stable(base_q));
endmodule

// File: rtl/pcicfg_rdpath.sv
module pcicfg_rdpath
  import pcicfg_pkg::*;
#(
  parameter logic [31:0] ID_WORD    = 32'h0001_121A,
  parameter logic [31:0] CLASS_WORD = 32'h0400_0002
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_en_i,
  input  logic [5:0]  rd_idx_i,
  input  logic [31:0] cmd_i,
  input  logic [31:0] base_i,
  input  logic [31:0] init_i,
  output logic        rd_valid_o,
  output logic [31:0] rd_data_o
);
  logic [31:0] mux_d, data_q;
  logic        valid_q;

  always_comb begin
    unique case (rd_idx_i)
      IDX_IDENT: mux_d = ID_WORD;
      IDX_CMD:   mux_d = cmd_i;
      IDX_CLASS: mux_d = CLASS_WORD;
      IDX_BASE:  mux_d = base_i;
      IDX_INIT:  mux_d = init_i;
      default:   mux_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= rd_en_i;
      if (rd_en_i) data_q <= mux_d;
    end
  end

  assign rd_valid_o = valid_q;
  assign rd_data_o  = data_q;

  a_r10_read_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);

  a_r10_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);

  a_r9_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_idx_i != IDX_IDENT && rd_idx_i != IDX_CMD && rd_idx_i != IDX_CLASS
     && rd_idx_i != IDX_BASE && rd_idx_i != IDX_INIT) |=> (rd_data_o == 32'h0));
endmodule

// File: rtl/pcicfg_memdec.sv
module pcicfg_memdec #(
  parameter int WIN_BITS = 24
) (
  input  logic        mem_en_i,
  input  logic [31:0] base_i,
  input  logic [31:0] addr_i,
  output logic        hit_o
);
  localparam int TAG_W = 32 - WIN_BITS;

  logic tag_eq;

  assign tag_eq = (addr_i[31 -: TAG_W] == base_i[31 -: TAG_W]);
  assign hit_o  = mem_en_i && tag_eq;

  always_comb begin
    if (!mem_en_i) a_r11_off_no_hit: assert (!hit_o);
  end
endmodule

// File: rtl/pcicfg_target.sv
module pcicfg_target
  import pcicfg_pkg::*;
#(
  parameter logic [31:0] ID_WORD     = 32'h0001_121A,
  parameter logic [31:0] CLASS_WORD  = 32'h0400_0002,
  parameter logic [31:0] CMD_MASK    = 32'h0000_0003,
  parameter int          WIN_BITS    = 24,
  parameter bit          BAR_MASK_WR = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        req_write_i,
  input  logic [7:0]  req_off_i,
  input  logic [3:0]  req_be_i,
  input  logic [31:0] req_wdata_i,
  output logic        rd_valid_o,
  output logic [31:0] rd_data_o,
  output logic [31:0] init_en_o,
  input  logic [31:0] mem_addr_i,
  output logic        mem_hit_o
);
  logic        rst_n;
  logic [5:0]  idx;
  logic        wr_en, rd_en;
  logic [31:0] cmd_w, base_w, init_w;

  assign idx   = req_off_i[7:2];
  assign wr_en = req_valid_i && req_write_i;
  assign rd_en = req_valid_i && !req_write_i;

  pcicfg_rstsync u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_n)
  );

  pcicfg_regs #(
    .CMD_MASK   (CMD_MASK),
    .WIN_BITS   (WIN_BITS),
    .BAR_MASK_WR(BAR_MASK_WR)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .wr_en_i  (wr_en),
    .wr_idx_i (idx),
    .wr_be_i  (req_be_i),
    .wr_data_i(req_wdata_i),
    .cmd_o    (cmd_w),
    .base_o   (base_w),
    .init_o   (init_w)
  );

  pcicfg_rdpath #(
    .ID_WORD   (ID_WORD),
    .CLASS_WORD(CLASS_WORD)
  ) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .rd_en_i   (rd_en),
    .rd_idx_i  (idx),
    .cmd_i     (cmd_w),
    .base_i    (base_w),
    .init_i    (init_w),
    .rd_valid_o(rd_valid_o),
    .rd_data_o (rd_data_o)
  );

  pcicfg_memdec #(
    .WIN_BITS(WIN_BITS)
  ) u_dec (
    .mem_en_i(cmd_w[1]),
    .base_i  (base_w),
    .addr_i  (mem_addr_i),
    .hit_o   (mem_hit_o)
  );

  assign init_en_o = init_w;

  a_r7_init_quiet: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(wr_en && idx == IDX_INIT) |=> $stable(init_en_o));

  a_r10_write_silent: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_en |=> !rd_valid_o);
endmodule

// File: tb/pcicfg_target_test.sv
module pcicfg_target_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_off = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0, mem_addr = '0;
  logic        rd_valid, mem_hit;
  logic [31:0] rd_data, init_en;

  int total = 0, bad = 0;
  bit done = 0;
  string cur_tag = "R1";

  always #10 clk = ~clk;

  pcicfg_target uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_off_i(req_off),
    .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .init_en_o(init_en),
    .mem_addr_i(mem_addr), .mem_hit_o(mem_hit)
  );

  // behavioural reference
  logic [31:0] m_cmd, m_bar, m_init, m_rdat;
  bit          m_rv;

  function automatic logic [31:0] m_read(input logic [7:0] off);
    case (off & 8'hFC)
      8'h00:   return 32'h0001_121A;
      8'h04:   return m_cmd;
      8'h08:   return 32'h0400_0002;
      8'h10:   return m_bar;
      8'h40:   return m_init;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] m_mix(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
    logic [31:0] r = o;
    if (be[0]) r[7:0]   = n[7:0];
    if (be[1]) r[15:8]  = n[15:8];
    if (be[2]) r[23:16] = n[23:16];
    if (be[3]) r[31:24] = n[31:24];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd = 0; m_bar = 0; m_init = 0; m_rv = 0; m_rdat = 0;
    end else begin
      m_rv = req_valid && !req_write;
      if (m_rv) m_rdat = m_read(req_off);
      if (req_valid && req_write) begin
        case (req_off & 8'hFC)
          8'h04: m_cmd = m_mix(m_cmd, req_wdata, req_be) & 32'h3;
          8'h10: m_bar = (req_be == 4'hF && req_wdata == 32'hFFFF_FFFF) ? 32'hFF00_0000
                         : m_mix(m_bar, req_wdata, req_be);
          8'h40: m_init = m_mix(m_init, req_wdata, req_be);
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({cur_tag, " R10 rd_valid"}, {31'h0, rd_valid}, {31'h0, m_rv});
      if (m_rv) check({cur_tag, " rd_data"}, rd_data, m_rdat);
      check({cur_tag, " R7 init_en"}, init_en, m_init);
      check({cur_tag, " R11 mem_hit"}, {31'h0, mem_hit},
            {31'h0, m_cmd[1] && (mem_addr[31:24] == m_bar[31:24])});
    end
  end

  task automatic issue(input bit w, input logic [7:0] off, input logic [3:0] be,
                       input logic [31:0] d);
    @(negedge clk); #2;
    req_valid = 1; req_write = w; req_off = off; req_be = be; req_wdata = d;
    @(posedge clk); #2;
    req_valid = 0; req_write = 0;
  endtask

  task automatic wr(input logic [7:0] off, input logic [3:0] be, input logic [31:0] d);
    issue(1, off, be, d);
  endtask

  task automatic rd_check(input string tag, input logic [7:0] off, input logic [31:0] exp);
    issue(0, off, 4'h0, 32'h0);
    @(negedge clk);
    check({tag, " valid"}, {31'h0, rd_valid}, 32'h1);
    check(tag, rd_data, exp);
  endtask

  task automatic hit_check(input string tag, input logic [31:0] a, input bit exp);
    @(negedge clk); #2;
    mem_addr = a;
    #1 check(tag, {31'h0, mem_hit}, {31'h0, exp});
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    cur_tag = "R1";
    check("R1 init_en reset", init_en, 32'h0);
    check("R1 mem_hit reset", {31'h0, mem_hit}, 32'h0);
    check("R1 rd_valid reset", {31'h0, rd_valid}, 32'h0);
    rd_check("R1 cmd reset", 8'h04, 32'h0);
    rd_check("R1 bar reset", 8'h10, 32'h0);
    rd_check("R1 init reset", 8'h40, 32'h0);

    cur_tag = "R2";
    rd_check("R2 ident", 8'h00, 32'h0001_121A);
    wr(8'h00, 4'hF, 32'hFFFF_FFFF);
    rd_check("R2 ident after write", 8'h00, 32'h0001_121A);

    cur_tag = "R3";
    wr(8'h08, 4'hF, 32'h0);
    rd_check("R3 class", 8'h08, 32'h0400_0002);

    cur_tag = "R4";
    wr(8'h04, 4'hF, 32'hFFFF_FFFF);
    rd_check("R4 cmd all ones", 8'h04, 32'h3);
    wr(8'h04, 4'hF, 32'h5);
    rd_check("R4 cmd alternating", 8'h04, 32'h1);

    cur_tag = "R5";
    wr(8'h10, 4'hF, 32'hFFFF_FFFF);
    rd_check("R5 size probe", 8'h10, 32'hFF00_0000);

    cur_tag = "R6";
    wr(8'h10, 4'hF, 32'h1234_5678);
    rd_check("R6 raw store", 8'h10, 32'h1234_5678);
    wr(8'h10, 4'hF, 32'h0A00_0000);
    rd_check("R6 base set", 8'h10, 32'h0A00_0000);

    cur_tag = "R8";
    wr(8'h10, 4'h3, 32'hAAAA_BBBB);
    rd_check("R8 low half", 8'h10, 32'h0A00_BBBB);
    wr(8'h10, 4'h7, 32'hFFFF_FFFF);
    rd_check("R8 partial probe", 8'h10, 32'h0AFF_FFFF);
    wr(8'h10, 4'hF, 32'h0A00_0000);
    wr(8'h40, 4'h8, 32'h5500_0000);
    rd_check("R8 init top byte", 8'h40, 32'h5500_0000);

    cur_tag = "R7";
    wr(8'h40, 4'hF, 32'h1234_5678);
    @(negedge clk);
    check("R7 init_en drive", init_en, 32'h1234_5678);
    rd_check("R7 init readback", 8'h40, 32'h1234_5678);

    cur_tag = "R9";
    wr(8'h3C, 4'hF, 32'hDEAD_BEEF);
    rd_check("R9 reserved read", 8'h3C, 32'h0);
    rd_check("R9 reserved 0x0C", 8'h0C, 32'h0);
    wr(8'h14, 4'hF, 32'hFFFF_FFFF);
    rd_check("R9 bar untouched", 8'h10, 32'h0A00_0000);
    rd_check("R9 low bits ignored", 8'h13, 32'h0A00_0000);

    cur_tag = "R10";
    wr(8'h40, 4'hF, 32'h0000_0001);
    @(negedge clk);
    check("R10 write no strobe", {31'h0, rd_valid}, 32'h0);

    cur_tag = "R11";
    wr(8'h04, 4'hF, 32'h2);
    hit_check("R11 inside", 32'h0A12_3456, 1);
    hit_check("R11 top edge", 32'h0AFF_FFFF, 1);
    hit_check("R11 above", 32'h0B00_0000, 0);
    hit_check("R11 below", 32'h09FF_FFFF, 0);
    wr(8'h04, 4'hF, 32'h1);
    hit_check("R11 decode off", 32'h0A00_0010, 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule